// File: doc/BRIEF.md
# Paged Window Register File with Pointer Stepping

This block holds the translation entries for a bank-switched memory window: sixty-four 16-bit entries, grouped as two sets of thirty-two. Software reaches them through two I/O ports. A pointer port at 0x1EE chooses an entry. A data port at 0x1EC reads or writes the chosen entry, with either a byte or a word transfer.

When bit 7 of the pointer is set, every data-port transfer advances the pointer. Software can then load or dump a whole set with a run of back-to-back transfers. Every data-port write raises a one-cycle notice that carries the entry index and a flag. The flag tells whether the entry lies in the set the translator is currently using.

The thirty-two entries of the selected set are exported continuously, so the translator downstream can use them without any port traffic.

Top module: `ems_page_file`

## Requirements
- R1: After a synchronous active-low reset, every entry holds 0x0000 and the pointer holds 0x00.
- R2: A write to the pointer port (0x1EE) loads the pointer from the low data byte. A read of that port returns the pointer in bits 7:0 and 0xFF in bits 15:8.
- R3: A byte write to the data port (0x1EC) stores the data byte in entry bits 7:0 and sets entry bits 15:8 to 0xFF.
- R4: A word write to the data port stores all 16 data bits unchanged.
- R5: A byte read of the data port returns entry bits 7:0 in bits 7:0, and bits 15:8 read as 0xFF.
- R6: A word read of the data port returns the entry ORed with 0xF000 when `wide_hi` is 1, and ORed with 0xFC00 when it is 0.
- R7: While pointer bit 7 is 1, each data-port read or write, of either size, adds one to pointer bits 5:0 at the closing clock edge. Bit 5:0 selects the entry, and bit 5 selects the set.
- R8: While pointer bit 7 is 0, data-port transfers leave the pointer unchanged.
- R9: When pointer bits 5:0 step past 63 they wrap to 0. Pointer bits 7:6 are never altered by stepping.
- R10: Each data-port write produces `upd_pulse` high for exactly one cycle, in the cycle after the write, with `upd_index` equal to the index that was written. No pulse appears otherwise.
- R11: `upd_live` accompanies each pulse. It is 1 exactly when `map_en` was 1 and `map_set` equalled index bit 5 during the write.
- R12: Slice i of `act_pages` (bits 16*i+15 : 16*i) equals entry (32*`map_set` + i). It reflects a write from the cycle after the write.
- R13: Accesses to any other address have no effect on entries or pointer. Their reads return 0xFFFF, and `io_rdata` is 0xFFFF whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current transfer |
| io_wdata | input | 16 | Write data (byte transfers use bits 7:0) |
| io_wr | input | 1 | Write strobe, one cycle per transfer |
| io_rd | input | 1 | Read strobe, one cycle per transfer |
| io_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| map_en | input | 1 | Window mapping enabled |
| map_set | input | 1 | Set currently used by the translator |
| wide_hi | input | 1 | Chooses the fixed high bits of word reads |
| io_rdata | output | 16 | Read data, valid while io_rd is high |
| upd_pulse | output | 1 | One-cycle notice of a data-port write |
| upd_index | output | 6 | Entry index carried by the notice |
| upd_live | output | 1 | Written entry belongs to the active set |
| act_pages | output | 512 | Thirty-two entries of the selected set |

## Verification
A corrupted pointer shows up on the very next data transfer, because the wrong entry is read or written. A pointer read-back exposes it directly, one cycle after the transfer that stepped it. A bad stored entry surfaces at once on `act_pages` when its set is selected, and otherwise on the next read of that index. Fault cases that would stay hidden are driven on purpose: the stepping wrap at 63, the preservation of pointer bits 7:6, and a stray or missing update notice, which is caught in the cycle where the notice should or should not appear.

// File: rtl/ems_pkg.sv
// Shared constants and types for the paged window register file.
// Assumes 16-bit entries and an 8-bit pointer register.
package ems_pkg;
    localparam int ENTRY_W = 16;
    localparam int BYTE_W  = 8;

    // Fixed high bits merged into word reads of the data port
    localparam logic [ENTRY_W-1:0] WORD_HI_WIDE   = 16'hF000;
    localparam logic [ENTRY_W-1:0] WORD_HI_NARROW = 16'hFC00;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_DATA = 2'd2
    } port_sel_e;
endpackage

// File: rtl/ems_ptr_reg.sv
// Entry pointer register. It loads from the pointer port. While its top
// bit is set, it steps the low index field on each data-port transfer.
// The index wraps modulo 2**IDX_W; the bits above the index are
// preserved. Assumes load and step are never requested together.
module ems_ptr_reg #(
    parameter int PTR_W = 8,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             xfer,
    output logic [PTR_W-1:0] ptr
);
    logic step_on;

    // Stepping is armed by the most significant pointer bit
    always_comb step_on = ptr[PTR_W-1];

    // Pointer state: reset, load, or step the index field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (xfer && step_on) begin
            ptr <= {ptr[PTR_W-1:IDX_W], IDX_W'(ptr[IDX_W-1:0] + 1'b1)};
        end
    end

    // R7: an armed transfer advances the index by one
    a_r7_step_index: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !load && ptr[PTR_W-1]) |=>
            (ptr[IDX_W-1:0] == IDX_W'($past(ptr[IDX_W-1:0]) + 1'b1)));

    // R8: an unarmed transfer leaves the pointer alone
    a_r8_hold_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !load && !ptr[PTR_W-1]) |=> $stable(ptr));

    // R9: stepping never disturbs the bits above the index
    a_r9_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (ptr[PTR_W-1:IDX_W] == $past(ptr[PTR_W-1:IDX_W])));
endmodule

// File: rtl/ems_page_bank.sv
// Storage for 2**IDX_W entries. Byte writes fill the upper byte with ones;
// word writes store the full value. Gives one random-read port and exports
// the half-bank picked by the set select.
module ems_page_bank
    import ems_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int SET_SZ  = ENTRIES / 2,
    localparam int SET_W   = IDX_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_word,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [ENTRY_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      set_sel,
    output logic [ENTRY_W-1:0]        rd_entry,
    output logic [SET_SZ*ENTRY_W-1:0] set_pages
);
    logic [ENTRY_W-1:0] mem [ENTRIES];
    logic [ENTRY_W-1:0] wr_val;

    // Form the stored value: a byte write fills the high byte with ones
    always_comb wr_val = wr_word ? wr_data
                                 : {{(ENTRY_W-BYTE_W){1'b1}}, wr_data[BYTE_W-1:0]};

    // Entry storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    // Random read for the data port
    always_comb rd_entry = mem[rd_idx];

    // Export every entry of the selected set
    for (genvar g = 0; g < SET_SZ; g++) begin : g_export
        always_comb set_pages[g*ENTRY_W +: ENTRY_W] = mem[{set_sel, SET_W'(g)}];
    end

    // R3: a byte write leaves ones in the upper byte
    a_r3_byte_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_word) |=>
            (mem[$past(wr_idx)][ENTRY_W-1:BYTE_W] == {(ENTRY_W-BYTE_W){1'b1}}));

    // R4: a word write keeps all bits
    a_r4_word_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/ems_rd_fmt.sv
// Formats read data for the two ports. Pointer reads and byte data reads
// pad with ones; word data reads merge in the mode-dependent high bits.
// Assumes PTR_W does not exceed ENTRY_W.
module ems_rd_fmt
    import ems_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic               rd,
    input  port_sel_e          sel,
    input  logic               word,
    input  logic               wide_hi,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ENTRY_W-1:0] rdata
);
    logic [ENTRY_W-1:0] hi_fill;

    // Pick the fixed bits that are ORed into word reads
    always_comb hi_fill = wide_hi ? WORD_HI_WIDE : WORD_HI_NARROW;

    // Read mux: ones whenever nothing of ours is being read
    always_comb begin
        rdata = '1;
        if (rd) begin
            unique case (sel)
                SEL_PTR:  rdata = {{(ENTRY_W-PTR_W){1'b1}}, ptr};
                SEL_DATA: rdata = word ? (entry | hi_fill)
                                       : {{(ENTRY_W-BYTE_W){1'b1}}, entry[BYTE_W-1:0]};
                default:  rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/ems_page_file.sv
// Top level of the paged window register file. It decodes the pointer and
// data ports, drives the pointer and the storage, and formats read data.
// It also issues a registered one-cycle notice for every data-port write.
// Assumes io_rd and io_wr are one-cycle strobes and never both high.
module ems_page_file
    import ems_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6,
    parameter int PTR_W  = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h01EC,
    parameter logic [ADDR_W-1:0] PTR_PORT  = 16'h01EE,
    localparam int SET_SZ = (1 << IDX_W) / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         io_addr,
    input  logic [ENTRY_W-1:0]        io_wdata,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic                      io_word,
    input  logic                      map_en,
    input  logic                      map_set,
    input  logic                      wide_hi,
    output logic [ENTRY_W-1:0]        io_rdata,
    output logic                      upd_pulse,
    output logic [IDX_W-1:0]          upd_index,
    output logic                      upd_live,
    output logic [SET_SZ*ENTRY_W-1:0] act_pages
);
    port_sel_e          sel;
    logic               ptr_load;
    logic               data_wr;
    logic               data_xfer;
    logic [PTR_W-1:0]   ptr;
    logic [ENTRY_W-1:0] cur_entry;

    // Address decode
    always_comb begin
        if (io_addr == PTR_PORT)       sel = SEL_PTR;
        else if (io_addr == DATA_PORT) sel = SEL_DATA;
        else                           sel = SEL_NONE;
    end

    // Transfer qualifiers
    always_comb begin
        ptr_load  = io_wr && (sel == SEL_PTR);
        data_wr   = io_wr && (sel == SEL_DATA);
        data_xfer = (io_wr || io_rd) && (sel == SEL_DATA);
    end

    ems_ptr_reg #(.PTR_W(PTR_W), .IDX_W(IDX_W)) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (io_wdata[PTR_W-1:0]),
        .xfer     (data_xfer),
        .ptr      (ptr)
    );

    ems_page_bank #(.IDX_W(IDX_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .wr_word   (io_word),
        .wr_idx    (ptr[IDX_W-1:0]),
        .wr_data   (io_wdata),
        .rd_idx    (ptr[IDX_W-1:0]),
        .set_sel   (map_set),
        .rd_entry  (cur_entry),
        .set_pages (act_pages)
    );

    ems_rd_fmt #(.PTR_W(PTR_W)) i_fmt (
        .rd      (io_rd),
        .sel     (sel),
        .word    (io_word),
        .wide_hi (wide_hi),
        .ptr     (ptr),
        .entry   (cur_entry),
        .rdata   (io_rdata)
    );

    // Update notice: registered one cycle after each data-port write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_index <= '0;
            upd_live  <= 1'b0;
        end else begin
            upd_pulse <= data_wr;
            if (data_wr) begin
                upd_index <= ptr[IDX_W-1:0];
                upd_live  <= map_en && (map_set == ptr[IDX_W-1]);
            end
        end
    end

    // R10: a data write is always followed by the notice
    a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (upd_pulse && upd_index == $past(ptr[IDX_W-1:0])));

    // R10: no notice without a preceding data write
    a_r10_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !upd_pulse);

    // R11: live flag matches the mapping inputs seen at the write
    a_r11_live_flag: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (upd_live == ($past(map_en) && ($past(map_set) == upd_index[IDX_W-1]))));
endmodule

// File: tb/test_ems_page_file.sv
`timescale 1ns/1ps
module test_ems_page_file;
    localparam logic [15:0] DPORT = 16'h01EC;
    localparam logic [15:0] PPORT = 16'h01EE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic io_wr = 1'b0, io_rd = 1'b0, io_word = 1'b0;
    logic map_en = 1'b1, map_set = 1'b0, wide_hi = 1'b0;
    logic [15:0] io_rdata;
    logic upd_pulse, upd_live;
    logic [5:0] upd_index;
    logic [511:0] act_pages;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Bench model
    logic [15:0] m_mem [64];
    logic [7:0]  m_ptr;

    // Scoreboard queues
    logic [15:0] rd_q [$];
    string       rd_tag_q [$];
    logic [6:0]  up_q [$];

    always #2.5 clk = ~clk;

    ems_page_file i_ems_page_file (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_word(io_word), .map_en(map_en),
        .map_set(map_set), .wide_hi(wide_hi), .io_rdata(io_rdata),
        .upd_pulse(upd_pulse), .upd_index(upd_index), .upd_live(upd_live),
        .act_pages(act_pages)
    );

    task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares reads and update notices against queued items
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (io_rd) begin
                if (rd_q.size() == 0) check(1'b0, "R13 unexpected read", io_rdata, 0);
                else begin
                    logic [15:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(io_rdata === e, t, io_rdata, e);
                end
            end
            if (upd_pulse) begin
                if (up_q.size() == 0) check(1'b0, "R10 stray pulse", 1, 0);
                else begin
                    logic [6:0] u;
                    u = up_q.pop_front();
                    check({upd_live, upd_index} === u, "R10/R11 notice", {upd_live, upd_index}, u);
                end
            end
        end
    end

    task automatic step_model();
        if (m_ptr[7]) m_ptr = {m_ptr[7:6], 6'(m_ptr[5:0] + 1'b1)};
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input bit word);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_word = word; io_wr = wr; io_rd = !wr;
        @(posedge clk); #1;
        io_wr = 1'b0; io_rd = 1'b0; io_addr = 16'h0000;
    endtask

    task automatic wr_ptr(input logic [7:0] v);
        m_ptr = v;
        access(1'b1, PPORT, {8'h00, v}, 1'b0);
    endtask

    task automatic wr_data(input logic [15:0] v, input bit word);
        logic [5:0] ix;
        ix = m_ptr[5:0];
        m_mem[ix] = word ? v : {8'hFF, v[7:0]};
        up_q.push_back({map_en && (map_set == ix[5]), ix});
        step_model();
        access(1'b1, DPORT, v, word);
    endtask

    task automatic rd_data(input bit word, input string tag);
        logic [15:0] e;
        e = m_mem[m_ptr[5:0]];
        e = word ? (e | (wide_hi ? 16'hF000 : 16'hFC00)) : {8'hFF, e[7:0]};
        rd_q.push_back(e); rd_tag_q.push_back(tag);
        step_model();
        access(1'b0, DPORT, 16'h0, word);
    endtask

    task automatic rd_ptr(input string tag);
        rd_q.push_back({8'hFF, m_ptr}); rd_tag_q.push_back(tag);
        access(1'b0, PPORT, 16'h0, 1'b0);
    endtask

    task automatic chk_export(input string tag);
        logic [511:0] e;
        @(negedge clk);
        for (int i = 0; i < 32; i++) e[i*16 +: 16] = m_mem[{map_set, 5'(i)}];
        check(act_pages === e, tag, act_pages, e);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 16'h0000;
        m_ptr = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_export("R1 entries clear (set 0)");
        check(upd_pulse === 1'b0, "R1 no notice after reset", upd_pulse, 0);
        rd_ptr("R1 R2 pointer clear");
        rd_data(1'b1, "R1 R6 word read of cleared entry narrow");

        // R2/R3/R5/R8: byte write with stepping off
        wr_ptr(8'h05);
        rd_ptr("R2 pointer readback");
        wr_data(16'h773C, 1'b0);
        rd_data(1'b1, "R3 byte write fills high byte");
        rd_data(1'b0, "R5 byte read");
        rd_ptr("R8 pointer held");

        // R4/R6: word write and both high-bit modes
        wr_data(16'h1234, 1'b1);
        rd_data(1'b1, "R4 R6 word read narrow");
        wide_hi = 1'b1;
        rd_data(1'b1, "R6 word read wide");
        rd_data(1'b0, "R5 byte read of word entry");
        wide_hi = 1'b0;

        // R7/R9/R11: stepping, wrap, inactive set
        wr_ptr(8'hBE);
        wr_data(16'hAAAA, 1'b1);
        rd_ptr("R7 step after word write");
        wr_data(16'h0055, 1'b0);
        rd_ptr("R9 wrap to 0 keeps bit 7");
        rd_data(1'b1, "R7 read at index 0");
        rd_ptr("R7 step after read");

        // R9: bits 7:6 survive a wrap
        wr_ptr(8'hFF);
        rd_data(1'b0, "R9 read at index 63");
        rd_ptr("R9 wrap keeps bits 7:6");

        // R7: fill set 1 with a burst of stepped writes
        wr_ptr(8'hA0);
        for (int i = 0; i < 32; i++) wr_data(16'h5000 + 16'(i * 3), (i % 2) == 0);
        rd_ptr("R7 R9 burst wraps to 0");

        // R12: export follows the set select
        chk_export("R12 export set 0");
        map_set = 1'b1;
        chk_export("R12 export set 1");

        // R11: live flag with mapping disabled and enabled
        wr_ptr(8'h21);
        map_en = 1'b0;
        wr_data(16'hBEEF, 1'b1);
        map_en = 1'b1;
        wr_data(16'hCAFE, 1'b1);
        chk_export("R12 export sees write");

        // R13: other addresses ignored
        access(1'b1, 16'h01ED, 16'h0077, 1'b0);
        access(1'b1, 16'h01EF, 16'h1111, 1'b1);
        rd_q.push_back(16'hFFFF); rd_tag_q.push_back("R13 other port reads ones");
        access(1'b0, 16'h01ED, 16'h0, 1'b1);
        rd_ptr("R13 pointer untouched");
        chk_export("R13 entries untouched");
        @(negedge clk);
        check(io_rdata === 16'hFFFF, "R13 idle read data", io_rdata, 16'hFFFF);

        repeat (3) @(posedge clk);
        check(rd_q.size() == 0 && up_q.size() == 0, "R10 all items seen",
              rd_q.size() + up_q.size(), 0);
        finish_run();
    end
endmodule